// File: doc/BRIEF.md
# Pixel Output Word Formatter

This block sits at the digital end of a scanner front end. Each converted pixel arrives as a 10-bit code with a one-cycle strobe, a 2-bit colour tag and an out-of-range flag. The block puts the pixel into a registered output word. It can send the word whole, or as two bytes one after the other on the upper eight lines of the bus.

In byte mode the first byte holds the eight most significant bits of the code. The second byte holds the two least significant bits and a set of status bits: the control-port kind (parallel or serial), the colour tag and the range flag. A stretch option holds the first byte for two clocks before the second byte, which matches a pixel period of three clocks.

An invert option complements the 10-bit code before it is split into bytes. It does not touch the status bits. The pad enable output follows an active-low enable input. That input has no effect on the output register.

Top module: `pixel_out_fmt`

## Requirements
- R1: While reset is asserted and after it is released, the bus word `bus_q` is zero until the first pixel strobe.
- R2: In word mode with inversion off, the edge that samples `pix_valid` loads `pix_data` unchanged into `bus_q[9:0]`, with bus bit 9 as the MSB.
- R3: With `cfg_invert` = 1, the code is complemented bit by bit before output, in word mode and in byte mode.
- R4: In byte mode, the edge that samples `pix_valid` puts code bits 9..2 on `bus_q[9:2]` and drives `bus_q[1:0]` to zero.
- R5: The second byte puts code bit 1 on `bus_q[9]` and code bit 0 on `bus_q[8]`, zeros on `bus_q[7:6]`, the port-kind bit on `bus_q[5]` (1 = parallel, 0 = serial), the colour tag on `bus_q[4:3]` and the range flag on `bus_q[2]` (1 = out of range). `bus_q[1:0]` is zero.
- R6: In byte mode with `cfg_stretch` = 0, the first byte lasts one clock and the second byte follows on the next edge.
- R7: With `cfg_stretch` = 1, the first byte lasts two clocks and the second byte follows on the third edge.
- R8: Inversion never changes the status bits of the second byte (`bus_q[5:2]`) or its zero bits.
- R9: `bus_en` equals the inverse of `oe_n` at all times (0 = bus released). Toggling `oe_n` never changes `bus_q`.
- R10: After the last part of a pixel has been shown, `bus_q` holds its value until the next pixel strobe.
- R11: The colour tag goes out exactly as given (00 red, 01 green, 10 blue). The block does not decode it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | One-cycle strobe: a new pixel is present |
| pix_data | input | 10 | Converted pixel code |
| pix_chan | input | 2 | Colour tag of the pixel |
| pix_ovr | input | 1 | Out-of-range flag of the pixel |
| cfg_narrow | input | 1 | 1 = two-byte output, 0 = whole word |
| cfg_invert | input | 1 | 1 = complement the code |
| cfg_stretch | input | 1 | 1 = hold the first byte for two clocks |
| cfg_par_if | input | 1 | Port-kind status bit reported in the second byte |
| oe_n | input | 1 | Output enable, active low |
| bus_q | output | 10 | Registered output word |
| bus_en | output | 1 | Pad driver enable: 1 = drive, 0 = high impedance |

## Verification
The sequence assertions assume that pixel strobes are spaced far enough apart for a byte-mode pixel to finish all its phases. They also assume the configuration inputs stay stable while a pixel is in flight. The bench sets the configuration only on the cycle of the strobe. It then waits out the full sequence of that pixel, and one extra hold cycle, before the next strobe. Random codes, tags, flags and modes from a fixed seed go through this fixed spacing. Directed all-ones, all-zeros and alternating codes cover the bit positions at their extremes.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LSB_W  = WORD_W - BYTE_W;
  localparam int unsigned TAG_W  = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_HOLD_A = 2'd1,
    SQ_SHOW_B = 2'd2
  } seq_e;

  function automatic word_t shape_word(input word_t raw, input logic inv);
    return inv ? ~raw : raw;
  endfunction

  function automatic byte_t upper_byte(input word_t w);
    return w[WORD_W-1:LSB_W];
  endfunction

  function automatic byte_t status_byte(input word_t w, input logic par,
                                        input logic [TAG_W-1:0] tag, input logic ovr);
    return {w[LSB_W-1:0], 2'b00, par, tag, ovr};
  endfunction

  function automatic word_t on_upper(input byte_t b);
    return {b, {LSB_W{1'b0}}};
  endfunction
endpackage

// File: rtl/ofmt_capture.sv
module ofmt_capture
  import ofmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  word_t            raw,
  input  logic             inv,
  input  logic             par,
  input  logic [TAG_W-1:0] tag,
  input  logic             ovr,
  output word_t            word_q,
  output logic             par_q,
  output logic [TAG_W-1:0] tag_q,
  output logic             ovr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      par_q  <= 1'b0;
      tag_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (take) begin
      word_q <= shape_word(raw, inv);
      par_q  <= par;
      tag_q  <= tag;
      ovr_q  <= ovr;
    end
  end
endmodule

// File: rtl/ofmt_sequencer.sv
module ofmt_sequencer
  import ofmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic narrow,
  input  logic stretch,
  output logic show_b,
  output logic seq_idle
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start) begin
      if (narrow) st_d = stretch ? SQ_HOLD_A : SQ_SHOW_B;
      else        st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_HOLD_A: st_d = SQ_SHOW_B;
        SQ_SHOW_B: st_d = SQ_IDLE;
        default:   st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign show_b   = (st_q == SQ_SHOW_B) && !start;
  assign seq_idle = (st_q == SQ_IDLE);
endmodule

// File: rtl/ofmt_drive.sv
module ofmt_drive
  import ofmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             narrow,
  input  logic             inv,
  input  word_t            raw,
  input  logic             show_b,
  input  word_t            held_word,
  input  logic             held_par,
  input  logic [TAG_W-1:0] held_tag,
  input  logic             held_ovr,
  output word_t            bus_q
);
  word_t live_word;
  assign live_word = shape_word(raw, inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
    end else if (start) begin
      bus_q <= narrow ? on_upper(upper_byte(live_word)) : live_word;
    end else if (show_b) begin
      bus_q <= on_upper(status_byte(held_word, held_par, held_tag, held_ovr));
    end
  end
endmodule

// File: rtl/pixel_out_fmt.sv
module pixel_out_fmt
  import ofmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_valid,
  input  logic [WORD_W-1:0]     pix_data,
  input  logic [TAG_W-1:0]      pix_chan,
  input  logic                  pix_ovr,
  input  logic                  cfg_narrow,
  input  logic                  cfg_invert,
  input  logic                  cfg_stretch,
  input  logic                  cfg_par_if,
  input  logic                  oe_n,
  output logic [WORD_W-1:0]     bus_q,
  output logic                  bus_en
);
  word_t            held_word;
  logic             held_par;
  logic [TAG_W-1:0] held_tag;
  logic             held_ovr;
  logic             show_b;
  logic             seq_idle;

  ofmt_capture u_capture (
    .clk(clk), .rst_n(rst_n), .take(pix_valid), .raw(pix_data),
    .inv(cfg_invert), .par(cfg_par_if), .tag(pix_chan), .ovr(pix_ovr),
    .word_q(held_word), .par_q(held_par), .tag_q(held_tag), .ovr_q(held_ovr)
  );

  ofmt_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(pix_valid), .narrow(cfg_narrow),
    .stretch(cfg_stretch), .show_b(show_b), .seq_idle(seq_idle)
  );

  ofmt_drive u_drive (
    .clk(clk), .rst_n(rst_n), .start(pix_valid), .narrow(cfg_narrow),
    .inv(cfg_invert), .raw(pix_data), .show_b(show_b),
    .held_word(held_word), .held_par(held_par), .held_tag(held_tag),
    .held_ovr(held_ovr), .bus_q(bus_q)
  );

  assign bus_en = !oe_n;
endmodule

// File: rtl/pixel_out_fmt_chk.sv
module pixel_out_fmt_chk
  import ofmt_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pix_valid,
  input logic [WORD_W-1:0]     pix_data,
  input logic                  cfg_narrow,
  input logic                  cfg_invert,
  input logic                  cfg_stretch,
  input logic                  oe_n,
  input logic [WORD_W-1:0]     bus_q,
  input logic                  bus_en,
  input logic                  show_b,
  input logic                  seq_idle
);
  // R2 R3
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !cfg_narrow |=>
      bus_q == ($past(cfg_invert) ? ~$past(pix_data) : $past(pix_data)));

  // R4
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && cfg_narrow |=>
      bus_q[1:0] == 2'b00 &&
      bus_q[9:2] == ($past(cfg_invert) ? ~$past(pix_data[9:2]) : $past(pix_data[9:2])));

  // R6
  quick_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && cfg_narrow && !cfg_stretch ##1 !pix_valid |=>
      bus_q[9:8] == ($past(cfg_invert, 2) ? ~$past(pix_data[1:0], 2) : $past(pix_data[1:0], 2)));

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && cfg_narrow && cfg_stretch ##1 !pix_valid |=> $stable(bus_q));

  // R5 R8
  status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    show_b |=> bus_q[7:6] == 2'b00 && bus_q[1:0] == 2'b00);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle && !pix_valid |=> $stable(bus_q));

  // R9
  enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en != oe_n);
endmodule

bind pixel_out_fmt pixel_out_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
  .cfg_narrow(cfg_narrow), .cfg_invert(cfg_invert), .cfg_stretch(cfg_stretch),
  .oe_n(oe_n), .bus_q(bus_q), .bus_en(bus_en), .show_b(show_b), .seq_idle(seq_idle)
);

// File: tb/test_pixel_out_fmt.sv
module test_pixel_out_fmt;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_valid;
  logic [9:0] pix_data;
  logic [1:0] pix_chan;
  logic       pix_ovr;
  logic       cfg_narrow, cfg_invert, cfg_stretch, cfg_par_if, oe_n;
  logic [9:0] bus_q;
  logic       bus_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pixel_out_fmt i_pixel_out_fmt (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_chan(pix_chan), .pix_ovr(pix_ovr), .cfg_narrow(cfg_narrow),
    .cfg_invert(cfg_invert), .cfg_stretch(cfg_stretch), .cfg_par_if(cfg_par_if),
    .oe_n(oe_n), .bus_q(bus_q), .bus_en(bus_en)
  );

  function automatic logic [9:0] want_word(input logic [9:0] d, input logic inv);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = inv ? !d[i] : d[i];
    return r;
  endfunction

  function automatic logic [9:0] want_a(input logic [9:0] w);
    return {w[9:2], 2'b00};
  endfunction

  function automatic logic [9:0] want_b(input logic [9:0] w, input logic par,
                                        input logic [1:0] ch, input logic ov);
    logic [9:0] r;
    r = '0;
    r[9] = w[1]; r[8] = w[0]; r[5] = par; r[4] = ch[1]; r[3] = ch[0]; r[2] = ov;
    return r;
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_pixel(input logic [9:0] d, input logic [1:0] ch, input logic ov,
                           input logic nar, input logic str, input logic inv, input logic par);
    logic [9:0] w;
    w = want_word(d, inv);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = d; pix_chan = ch; pix_ovr = ov;
    cfg_narrow = nar; cfg_stretch = str; cfg_invert = inv; cfg_par_if = par;
    @(negedge clk);
    pix_valid = 1'b0;
    if (!nar) begin
      check(inv ? "R3 word inverted" : "R2 word", bus_q, w);
      @(negedge clk);
      check("R10 word hold", bus_q, w);
    end else begin
      check(inv ? "R3 R4 first byte" : "R4 first byte", bus_q, want_a(w));
      if (str) begin
        @(negedge clk);
        check("R7 first byte held", bus_q, want_a(w));
      end
      @(negedge clk);
      check(str ? "R7 R5 second byte" : "R6 R5 second byte", bus_q, want_b(w, par, ch, ov));
      if (inv) check("R8 status not inverted", {6'b0, bus_q[5:2]}, {6'b0, par, ch, ov});
      check("R11 tag field", {8'b0, bus_q[4:3]}, {8'b0, ch});
      @(negedge clk);
      check("R10 second byte hold", bus_q, want_b(w, par, ch, ov));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] hold;
    void'($urandom(32'd4411));
    rst_n = 1'b0; pix_valid = 1'b0; pix_data = '0; pix_chan = '0; pix_ovr = 1'b0;
    cfg_narrow = 1'b0; cfg_invert = 1'b0; cfg_stretch = 1'b0; cfg_par_if = 1'b0; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset word", bus_q, 10'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", bus_q, 10'h000);
    check("R9 released", {9'b0, bus_en}, 10'h000);

    run_pixel(10'h3FF, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_pixel(10'h2AA, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_pixel(10'h000, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    run_pixel(10'h3FF, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_pixel(10'h155, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    run_pixel(10'h000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

    hold = bus_q;
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    check("R9 drive enable", {9'b0, bus_en}, 10'h001);
    check("R9 word untouched", bus_q, hold);
    oe_n = 1'b1;
    @(negedge clk);
    check("R9 release", {9'b0, bus_en}, 10'h000);
    check("R9 word untouched again", bus_q, hold);

    for (int n = 0; n < 300; n++) begin
      logic [1:0] ch;
      ch = 2'($urandom_range(0, 2));
      oe_n = 1'($urandom);
      run_pixel(10'($urandom), ch, 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom));
      check("R9 enable follows", {9'b0, bus_en}, {9'b0, !oe_n});
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule